// File: doc/BRIEF.md
# Integer Fault Condition Monitor

This block sits beside the instruction register of an integer core and watches the current instruction word and the value of its second source register. It raises two flags as safety properties, and neither flag changes any architectural result. The first flag marks an immediate shift whose encoding uses the sixth shift-amount bit while that bit is reserved. On a 64-bit target this applies to the word-shift opcode only. On a 32-bit target it applies to the plain immediate opcode. The second flag marks a divide or remainder instruction whose divisor register holds zero.

The monitor is purely combinational, so both flags follow their inputs within the same cycle. Two parameters select its variant. `IS_RV64` picks the target width, and with it the width of the divisor input and the opcode that the shift check watches. `M_EXT` turns the multiply/divide group on or off. A formal harness or a simulation checker can take the two flags as properties that must never be set.

Top module: `rvfc_fault_monitor`

## Requirements
- R1: With `IS_RV64`=1, `illegal_shift_o` is 1 when opcode (bits 6:0) is 7'b0011011 and either funct3 (bits 14:12) is 001 with funct7 (bits 31:25) 7'b0000001, or funct3 is 101 with funct7 7'b0000001 or 7'b0100001.
- R2: With `IS_RV64`=1, opcode 7'b0010011 never raises `illegal_shift_o`, whatever its funct7 and funct3 are.
- R3: With `IS_RV64`=0, the R1 patterns raise `illegal_shift_o` under opcode 7'b0010011, and opcode 7'b0011011 raises nothing.
- R4: Under the watched shift opcode, legal shift funct7 values (7'b0000000 and 7'b0100000) and any funct3 other than 001 or 101 leave `illegal_shift_o` at 0.
- R5: `div_by_zero_o` is 1 for opcode 7'b0110011 with funct7 7'b0000001, funct3 in {100, 101, 110, 111}, and `rs2_value_i` equal to zero.
- R6: With `IS_RV64`=1, the same funct7/funct3 pattern under opcode 7'b0111011 with a zero `rs2_value_i` raises `div_by_zero_o`.
- R7: The zero test covers the whole `rs2_value_i` word, including word-sized divides. A divisor whose low 32 bits are zero but whose upper bits are not zero gives 0.
- R8: Multiplies never raise `div_by_zero_o`. These are funct3 000 to 011 under opcode 7'b0110011, and funct3 000 under 7'b0111011. Other funct3 values under 7'b0111011 that are not divides also leave the flag at 0.
- R9: A nonzero `rs2_value_i`, or a funct7 other than 7'b0000001, leaves `div_by_zero_o` at 0.
- R10: With `IS_RV64`=0, opcode 7'b0111011 never raises `div_by_zero_o`.
- R11: With `M_EXT`=0, `div_by_zero_o` stays 0 for every input, and the shift check keeps working.
- R12: The two flags are never 1 together. An all-zero instruction word gives 0 on both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word under observation |
| rs2_value_i | input | XLEN (64 if IS_RV64, else 32) | Current value of the second source register |
| illegal_shift_o | output | 1 | Reserved shift-amount encoding detected |
| div_by_zero_o | output | 1 | Divide or remainder with a zero divisor detected |

## Verification
Both flags are due in the same cycle as the stimulus, because no register lies between any input and either output. The bench drives the instruction and the divisor just after a rising edge and reads the flags at the following falling edge, half a period later, so the values have settled before they are compared. Three instances share the instruction input and cover the 64-bit target, the 32-bit target and the variant without multiply/divide. Each instance is checked against expected values that the bench builds from the encodings in the requirements.

// File: rtl/rvfc_pkg.sv
`timescale 1ns/1ps
package rvfc_pkg;

  localparam int ILEN = 32;

  localparam logic [6:0] OPC_IMM   = 7'b0010011;
  localparam logic [6:0] OPC_IMM32 = 7'b0011011;
  localparam logic [6:0] OPC_REG   = 7'b0110011;
  localparam logic [6:0] OPC_REG32 = 7'b0111011;

  localparam logic [6:0] F7_MULDIV  = 7'b0000001;
  localparam logic [6:0] F7_LOG_BAD = 7'b0000001;
  localparam logic [6:0] F7_ARI_BAD = 7'b0100001;

  localparam logic [2:0] F3_SHL    = 3'b001;
  localparam logic [2:0] F3_SHR    = 3'b101;
  localparam logic [2:0] F3_MUL    = 3'b000;
  localparam logic [2:0] F3_DIV    = 3'b100;
  localparam logic [2:0] F3_DIVU   = 3'b101;
  localparam logic [2:0] F3_REM    = 3'b110;
  localparam logic [2:0] F3_REMU   = 3'b111;

  typedef struct packed {
    logic [6:0] funct7;
    logic [4:0] rs2;
    logic [4:0] rs1;
    logic [2:0] funct3;
    logic [4:0] rd;
    logic [6:0] opcode;
  } rv_fields_t;

  function automatic rv_fields_t split_instr(input logic [ILEN-1:0] w);
    return rv_fields_t'(w);
  endfunction

  // Reserved high shift-amount bit for a 32-bit shift encoding.
  function automatic logic shamt_hi_reserved(input logic [2:0] f3, input logic [6:0] f7);
    logic r;
    case (f3)
      F3_SHL:  r = (f7 == F7_LOG_BAD);
      F3_SHR:  r = (f7 == F7_LOG_BAD) || (f7 == F7_ARI_BAD);
      default: r = 1'b0;
    endcase
    return r;
  endfunction

  function automatic logic is_divrem_f3(input logic [2:0] f3);
    return (f3 == F3_DIV) || (f3 == F3_DIVU) || (f3 == F3_REM) || (f3 == F3_REMU);
  endfunction

  function automatic logic is_mul_f3(input logic [2:0] f3, input logic word_form);
    return word_form ? (f3 == F3_MUL) : (f3[2] == 1'b0);
  endfunction

endpackage

// File: rtl/rvfc_shift_chk.sv
`timescale 1ns/1ps
module rvfc_shift_chk
  import rvfc_pkg::*;
#(
  parameter bit IS_RV64 = 1'b1
) (
  input  rv_fields_t fields_i,
  output logic       opc_hit_o,
  output logic       illegal_o
);

  localparam logic [6:0] WATCH_OPC = IS_RV64 ? OPC_IMM32 : OPC_IMM;

  assign opc_hit_o = (fields_i.opcode == WATCH_OPC);
  assign illegal_o = opc_hit_o && shamt_hi_reserved(fields_i.funct3, fields_i.funct7);

endmodule

// File: rtl/rvfc_mdiv_decode.sv
`timescale 1ns/1ps
module rvfc_mdiv_decode
  import rvfc_pkg::*;
#(
  parameter bit IS_RV64 = 1'b1,
  parameter bit M_EXT   = 1'b1
) (
  input  rv_fields_t fields_i,
  output logic       divrem_o,
  output logic       mul_o
);

  logic m_group;
  logic reg_hit;
  logic word_hit;

  assign m_group = (fields_i.funct7 == F7_MULDIV);
  assign reg_hit = (fields_i.opcode == OPC_REG);

  generate
    if (IS_RV64) begin : g_word
      assign word_hit = (fields_i.opcode == OPC_REG32);
    end else begin : g_noword
      assign word_hit = 1'b0;
    end

    if (M_EXT) begin : g_mext
      assign divrem_o = m_group && (reg_hit || word_hit) && is_divrem_f3(fields_i.funct3);
      assign mul_o    = m_group && ((reg_hit  && is_mul_f3(fields_i.funct3, 1'b0)) ||
                                    (word_hit && is_mul_f3(fields_i.funct3, 1'b1)));
    end else begin : g_nomext
      assign divrem_o = 1'b0;
      assign mul_o    = 1'b0;
    end
  endgenerate

  // R8: a multiply is never also classed as a divide
  always_comb begin
    a_r8_mul_not_div: assert (!(mul_o && divrem_o))
      else $error("a_r8_mul_not_div: multiply decoded as divide");
  end

endmodule

// File: rtl/rvfc_zero_cmp.sv
`timescale 1ns/1ps
module rvfc_zero_cmp #(
  parameter int W = 64
) (
  input  logic [W-1:0] value_i,
  output logic         zero_o
);

  assign zero_o = ~|value_i;

endmodule

// File: rtl/rvfc_fault_monitor.sv
`timescale 1ns/1ps
module rvfc_fault_monitor
  import rvfc_pkg::*;
#(
  parameter bit IS_RV64 = 1'b1,
  parameter bit M_EXT   = 1'b1,
  localparam int XLEN   = IS_RV64 ? 64 : 32
) (
  input  logic [ILEN-1:0] instr_i,
  input  logic [XLEN-1:0] rs2_value_i,
  output logic            illegal_shift_o,
  output logic            div_by_zero_o
);

  rv_fields_t fields;
  logic       shift_opc_hit;
  logic       is_divrem;
  logic       is_mul;
  logic       rs2_zero;

  assign fields = split_instr(instr_i);

  rvfc_shift_chk #(.IS_RV64(IS_RV64)) u_shift (
    .fields_i (fields),
    .opc_hit_o(shift_opc_hit),
    .illegal_o(illegal_shift_o)
  );

  rvfc_mdiv_decode #(.IS_RV64(IS_RV64), .M_EXT(M_EXT)) u_mdiv (
    .fields_i(fields),
    .divrem_o(is_divrem),
    .mul_o   (is_mul)
  );

  rvfc_zero_cmp #(.W(XLEN)) u_zero (
    .value_i(rs2_value_i),
    .zero_o (rs2_zero)
  );

  assign div_by_zero_o = is_divrem && rs2_zero;

  // R12: the two flags come from disjoint opcode groups
  always_comb begin
    a_r12_flags_exclusive: assert (!(illegal_shift_o && div_by_zero_o))
      else $error("a_r12_flags_exclusive: both flags set");
  end

  // R7: a raised divide flag means the full divisor word is zero
  always_comb begin
    a_r7_full_word_zero: assert (!div_by_zero_o || (rs2_value_i == '0))
      else $error("a_r7_full_word_zero: flag with nonzero divisor");
  end

  // R8: multiplies keep the divide flag low
  always_comb begin
    a_r8_mul_quiet: assert (!(is_mul && div_by_zero_o))
      else $error("a_r8_mul_quiet: multiply raised divide flag");
  end

  // R1/R3: a shift flag only appears under the watched opcode
  always_comb begin
    a_r1_shift_opcode: assert (!illegal_shift_o || shift_opc_hit)
      else $error("a_r1_shift_opcode: flag outside watched opcode");
  end

  generate
    if (!M_EXT) begin : g_chk_nomext
      // R11: no multiply/divide group, no divide flag
      always_comb begin
        a_r11_mext_off: assert (!div_by_zero_o)
          else $error("a_r11_mext_off: divide flag without M group");
      end
    end
  endgenerate

endmodule

// File: tb/test_rvfc_fault_monitor.sv
`timescale 1ns/1ps
module test_rvfc_fault_monitor;

  localparam logic [6:0] OI   = 7'b0010011;
  localparam logic [6:0] OI32 = 7'b0011011;
  localparam logic [6:0] OR   = 7'b0110011;
  localparam logic [6:0] OR32 = 7'b0111011;
  localparam int NROWS = 28;
  localparam int WATCHDOG_NS = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [31:0] instr = '0;
  logic [63:0] rs2_64 = '0;
  logic [31:0] rs2_32 = '0;
  logic ill64, dz64, ill32, dz32, illnm, dznm;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  rvfc_fault_monitor i_rvfc_fault_monitor (
    .instr_i(instr), .rs2_value_i(rs2_64),
    .illegal_shift_o(ill64), .div_by_zero_o(dz64));

  rvfc_fault_monitor #(.IS_RV64(1'b0)) i_rvfc_fault_monitor_rv32 (
    .instr_i(instr), .rs2_value_i(rs2_32),
    .illegal_shift_o(ill32), .div_by_zero_o(dz32));

  rvfc_fault_monitor #(.M_EXT(1'b0)) i_rvfc_fault_monitor_nom (
    .instr_i(instr), .rs2_value_i(rs2_64),
    .illegal_shift_o(illnm), .div_by_zero_o(dznm));

  function automatic logic [31:0] mk(input logic [6:0] f7, input logic [2:0] f3, input logic [6:0] op);
    return {f7, 5'd5, 5'd6, f3, 5'd7, op};
  endfunction

  function automatic logic [101:0] row(input logic [3:0] req, input logic [31:0] w,
                                       input logic [63:0] v, input logic ei, input logic ed);
    return {req, w, v, ei, ed};
  endfunction

  localparam logic [101:0] TBL [NROWS] = '{
    row(4'd1,  mk(7'b0000001, 3'b001, OI32), 64'd9, 1'b1, 1'b0),  // R1 slli bad
    row(4'd1,  mk(7'b0000001, 3'b101, OI32), 64'd0, 1'b1, 1'b0),  // R1 srli bad
    row(4'd1,  mk(7'b0100001, 3'b101, OI32), 64'd3, 1'b1, 1'b0),  // R1 srai bad
    row(4'd2,  mk(7'b0000001, 3'b001, OI),   64'd0, 1'b0, 1'b0),  // R2
    row(4'd2,  mk(7'b0100001, 3'b101, OI),   64'd0, 1'b0, 1'b0),  // R2
    row(4'd4,  mk(7'b0000000, 3'b001, OI32), 64'd0, 1'b0, 1'b0),  // R4 legal slliw
    row(4'd4,  mk(7'b0100000, 3'b101, OI32), 64'd0, 1'b0, 1'b0),  // R4 legal sraiw
    row(4'd4,  mk(7'b0000001, 3'b000, OI32), 64'd0, 1'b0, 1'b0),  // R4 non-shift funct3
    row(4'd5,  mk(7'b0000001, 3'b100, OR),   64'd0, 1'b0, 1'b1),  // R5 div
    row(4'd5,  mk(7'b0000001, 3'b101, OR),   64'd0, 1'b0, 1'b1),  // R5 divu
    row(4'd5,  mk(7'b0000001, 3'b110, OR),   64'd0, 1'b0, 1'b1),  // R5 rem
    row(4'd5,  mk(7'b0000001, 3'b111, OR),   64'd0, 1'b0, 1'b1),  // R5 remu
    row(4'd6,  mk(7'b0000001, 3'b100, OR32), 64'd0, 1'b0, 1'b1),  // R6 divw
    row(4'd6,  mk(7'b0000001, 3'b101, OR32), 64'd0, 1'b0, 1'b1),  // R6 divuw
    row(4'd6,  mk(7'b0000001, 3'b110, OR32), 64'd0, 1'b0, 1'b1),  // R6 remw
    row(4'd6,  mk(7'b0000001, 3'b111, OR32), 64'd0, 1'b0, 1'b1),  // R6 remuw
    row(4'd7,  mk(7'b0000001, 3'b100, OR32), 64'h1_0000_0000, 1'b0, 1'b0),  // R7
    row(4'd7,  mk(7'b0000001, 3'b110, OR),   64'hFFFF_FFFF_0000_0000, 1'b0, 1'b0),  // R7
    row(4'd8,  mk(7'b0000001, 3'b000, OR),   64'd0, 1'b0, 1'b0),  // R8 mul
    row(4'd8,  mk(7'b0000001, 3'b001, OR),   64'd0, 1'b0, 1'b0),  // R8 mulh
    row(4'd8,  mk(7'b0000001, 3'b010, OR),   64'd0, 1'b0, 1'b0),  // R8 mulhsu
    row(4'd8,  mk(7'b0000001, 3'b011, OR),   64'd0, 1'b0, 1'b0),  // R8 mulhu
    row(4'd8,  mk(7'b0000001, 3'b000, OR32), 64'd0, 1'b0, 1'b0),  // R8 mulw
    row(4'd8,  mk(7'b0000001, 3'b001, OR32), 64'd0, 1'b0, 1'b0),  // R8 undefined word op
    row(4'd9,  mk(7'b0000001, 3'b100, OR),   64'd1, 1'b0, 1'b0),  // R9 nonzero
    row(4'd9,  mk(7'b0000001, 3'b111, OR32), 64'h8000_0000_0000_0000, 1'b0, 1'b0),  // R9
    row(4'd9,  mk(7'b0000000, 3'b100, OR),   64'd0, 1'b0, 1'b0),  // R9 xor
    row(4'd12, mk(7'b0100001, 3'b101, OI32), 64'd0, 1'b1, 1'b0)   // R12 only one flag
  };

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w, input logic [63:0] v);
    @(posedge clk);
    #0.5;
    instr  = w;
    rs2_64 = v;
    rs2_32 = v[31:0];
    @(negedge clk);
  endtask

  initial begin
    #(WATCHDOG_NS * 1ns);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R12 reset state: all-zero instruction gives no flags
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R12", "reset illegal", ill64, 1'b0);
    check("R12", "reset divzero", dz64, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NROWS; i++) begin
      logic [101:0] r;
      r = TBL[i];
      apply(r[97:66], r[65:2]);
      check($sformatf("R%0d", r[101:98]), $sformatf("row %0d illegal", i), ill64, r[1]);
      check($sformatf("R%0d", r[101:98]), $sformatf("row %0d divzero", i), dz64, r[0]);
    end

    // R3: 32-bit target watches the plain immediate opcode
    apply(mk(7'b0000001, 3'b001, OI), 64'd0);
    check("R3", "rv32 slli bad", ill32, 1'b1);
    apply(mk(7'b0100001, 3'b101, OI), 64'd0);
    check("R3", "rv32 srai bad", ill32, 1'b1);
    apply(mk(7'b0000001, 3'b001, OI32), 64'd0);
    check("R3", "rv32 word opcode ignored", ill32, 1'b0);

    // R10: 32-bit target has no word divides
    apply(mk(7'b0000001, 3'b100, OR32), 64'd0);
    check("R10", "rv32 divw", dz32, 1'b0);
    apply(mk(7'b0000001, 3'b111, OR), 64'd0);
    check("R5", "rv32 remu", dz32, 1'b1);

    // R11: without the M group the divide flag stays low
    apply(mk(7'b0000001, 3'b100, OR), 64'd0);
    check("R11", "no-M div", dznm, 1'b0);
    apply(mk(7'b0000001, 3'b110, OR32), 64'd0);
    check("R11", "no-M remw", dznm, 1'b0);
    apply(mk(7'b0000001, 3'b101, OI32), 64'd0);
    check("R11", "no-M shift check", illnm, 1'b1);

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule